// File: doc/BRIEF.md
# Prioritised Interrupt Arbiter with Vector Generation

This block chooses one interrupt among the requests of four serial channels and two counter/timers, and presents it to a host processor. Each channel has an 8-bit bid register. The register gives a 3-bit priority to a received-break request and a 3-bit priority to an input-change request. The odd channels also give a 2-bit priority to the counter/timer attached to them. A combinational scan picks the highest bid. The host interrupt line goes low only when that bid is strictly greater than a 6-bit threshold.

When the host pulls the acknowledge line low, the block captures the current winner into an internal record: channel code, type code and priority. It holds that record until the acknowledge ends. The vector output is built from the record and an 8-bit base vector. One of four modes selects how it is built: the plain base vector, the base vector with the channel code merged in, the base vector with the type code and the channel code merged in, or a fixed 0xFF. The request sources are outside this block.

The channel field of the vector is 2 bits wide, so the block is built for four channels.

Top module: `prio_irq_arb`

## Requirements
- R1: After reset, all four bid registers and the control register read 0x00, and `irq_no` is high.
- R2: Bid register n sits at address 0x20+n and is read/write. Its fields are break priority in [7:5], change priority in [4:2] and timer priority in [1:0]. The control register at 0x2C is read/write, with the threshold in [7:2] and the vector mode in [1:0].
- R3: `irq_no` is registered. One cycle after a winning bid whose priority is strictly greater than the threshold is present, `irq_no` is low. Otherwise it is high. A priority of zero never wins.
- R4: The highest priority wins. On equal priorities the lower channel wins. Within one channel the order is break, then change, then timer.
- R5: Timer 0 bids with the timer field of channel 1 and reports channel code 01. Timer 1 bids with the timer field of channel 3 and reports channel code 11.
- R6: The first clock edge that samples `iack_ni` low captures the winner into the record. The record does not change for the rest of the acknowledge, even if the requests change.
- R7: The type codes are break 001, change 010, timer 100, and none 000. In mode 00, `vec_o` is the base vector. In mode 01, it is base[7:2] followed by the channel code. In mode 10, it is base[7:5], then the type code, then the channel code.
- R8: In mode 11, `vec_o` is 0xFF.
- R9: `irq_no` stays high while the acknowledge is low and for one cycle after it rises. After that it follows the current requests again.
- R10: The base vector at 0x29 is write-only and reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| brk_req_i | input | 4 | Received-break request, one bit per channel |
| chg_req_i | input | 4 | Input-change request, one bit per channel |
| ct_req_i | input | 2 | Counter/timer requests |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational from `addr_i` |
| iack_ni | input | 1 | Interrupt acknowledge, active low |
| irq_no | output | 1 | Host interrupt, active low |
| vec_o | output | 8 | Vector byte built from the captured record |

## Verification
The hardest case to reach is a change in the requests while an acknowledge is in progress. A correct design must keep the captured record and must not raise the interrupt again until one cycle after the release. To get there, the bench clears every request after the capture edge and then steps through all four vector modes during the same acknowledge, so each mode is compared against a winner that no longer exists at the inputs. Priorities, requests and thresholds come from a seeded sweep, with directed cases for ties across channels, ties within a channel, and the two timer channel codes.

// File: rtl/iarb_pkg.sv
package iarb_pkg;
  typedef enum logic [2:0] {
    SRC_NONE = 3'b000,
    SRC_BRK  = 3'b001,
    SRC_CHG  = 3'b010,
    SRC_TMR  = 3'b100
  } src_type_e;

  typedef enum logic [1:0] {
    VM_FULL  = 2'b00,
    VM_CH    = 2'b01,
    VM_TY_CH = 2'b10,
    VM_OFF   = 2'b11
  } vec_mode_e;
endpackage

// File: rtl/iarb_regs.sv
module iarb_regs #(
  parameter int NCH = 4,
  parameter int AW  = 8,
  parameter logic [AW-1:0] BID_BASE = 8'h20,
  parameter logic [AW-1:0] BASE_VEC = 8'h29,
  parameter logic [AW-1:0] CTRL_ADR = 8'h2C
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           rdata_o,
  output logic [NCH-1:0][7:0]  bid_o,
  output logic [7:0]           ctrl_o,
  output logic [7:0]           base_o
);
  logic [NCH-1:0][7:0] bid_q;
  logic [7:0] ctrl_q, base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bid_q  <= '0;
      ctrl_q <= '0;
      base_q <= '0;
    end else if (wr_en_i) begin
      for (int c = 0; c < NCH; c++)
        if (addr_i == BID_BASE + AW'(c)) bid_q[c] <= wdata_i;
      if (addr_i == CTRL_ADR) ctrl_q <= wdata_i;
      if (addr_i == BASE_VEC) base_q <= wdata_i;
    end
  end

  // base vector is write-only: no read path
  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NCH; c++)
      if (addr_i == BID_BASE + AW'(c)) rdata_o = bid_q[c];
    if (addr_i == CTRL_ADR) rdata_o = ctrl_q;
  end

  assign bid_o  = bid_q;
  assign ctrl_o = ctrl_q;
  assign base_o = base_q;
endmodule

// File: rtl/iarb_pick.sv
module iarb_pick
  import iarb_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int NTMR = NCH / 2,
  localparam int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0]       brk_req_i,
  input  logic [NCH-1:0]       chg_req_i,
  input  logic [NTMR-1:0]      ct_req_i,
  input  logic [NCH-1:0][7:0]  bid_i,
  output logic [2:0]           win_prio_o,
  output logic [CHW-1:0]       win_ch_o,
  output src_type_e            win_type_o
);
  // strict compare in scan order gives the fixed tie order
  always_comb begin
    win_prio_o = '0;
    win_ch_o   = '0;
    win_type_o = SRC_NONE;
    for (int c = 0; c < NCH; c++) begin
      if (brk_req_i[c] && bid_i[c][7:5] > win_prio_o) begin
        win_prio_o = bid_i[c][7:5];
        win_ch_o   = CHW'(c);
        win_type_o = SRC_BRK;
      end
      if (chg_req_i[c] && bid_i[c][4:2] > win_prio_o) begin
        win_prio_o = bid_i[c][4:2];
        win_ch_o   = CHW'(c);
        win_type_o = SRC_CHG;
      end
      if ((c % 2 == 1) && ct_req_i[c/2] && {1'b0, bid_i[c][1:0]} > win_prio_o) begin
        win_prio_o = {1'b0, bid_i[c][1:0]};
        win_ch_o   = CHW'(c);
        win_type_o = SRC_TMR;
      end
    end
  end
endmodule

// File: rtl/iarb_vec.sv
module iarb_vec
  import iarb_pkg::*;
(
  input  vec_mode_e  mode_i,
  input  logic [7:0] base_i,
  input  logic [1:0] ch_i,
  input  src_type_e  type_i,
  output logic [7:0] vec_o
);
  always_comb begin
    unique case (mode_i)
      VM_FULL:  vec_o = base_i;
      VM_CH:    vec_o = {base_i[7:2], ch_i};
      VM_TY_CH: vec_o = {base_i[7:5], type_i, ch_i};
      default:  vec_o = 8'hFF;
    endcase
  end
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
  import iarb_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int NTMR = NCH / 2,
  parameter int AW   = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCH-1:0]  brk_req_i,
  input  logic [NCH-1:0]  chg_req_i,
  input  logic [NTMR-1:0] ct_req_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [7:0]      wdata_i,
  output logic [7:0]      rdata_o,
  input  logic            iack_ni,
  output logic            irq_no,
  output logic [7:0]      vec_o
);
  localparam int CHW = $clog2(NCH);

  logic [NCH-1:0][7:0] bid;
  logic [7:0]          ctrl, base;
  logic [2:0]          win_prio;
  logic [CHW-1:0]      win_ch;
  src_type_e           win_type;
  logic                above;
  logic                ack_d;
  logic                irq_q;
  logic [CHW-1:0]      cir_ch;
  src_type_e           cir_type;
  logic [2:0]          cir_prio;

  iarb_regs #(.NCH(NCH), .AW(AW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .bid_o(bid), .ctrl_o(ctrl),
    .base_o(base)
  );

  iarb_pick #(.NCH(NCH), .NTMR(NTMR)) u_pick (
    .brk_req_i(brk_req_i), .chg_req_i(chg_req_i), .ct_req_i(ct_req_i),
    .bid_i(bid), .win_prio_o(win_prio), .win_ch_o(win_ch),
    .win_type_o(win_type)
  );

  assign above = {3'b000, win_prio} > ctrl[7:2];

  // ack_d high = previous sample was idle; low for one cycle after release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_d    <= 1'b1;
      irq_q    <= 1'b0;
      cir_ch   <= '0;
      cir_type <= SRC_NONE;
      cir_prio <= '0;
    end else begin
      ack_d <= iack_ni;
      irq_q <= above && iack_ni && ack_d;
      if (ack_d && !iack_ni) begin
        cir_ch   <= win_ch;
        cir_type <= win_type;
        cir_prio <= win_prio;
      end
    end
  end

  assign irq_no = ~irq_q;

  iarb_vec u_vec (
    .mode_i(vec_mode_e'(ctrl[1:0])), .base_i(base), .ch_i(cir_ch),
    .type_i(cir_type), .vec_o(vec_o)
  );
endmodule

// File: rtl/prio_irq_arb_chk.sv
module prio_irq_arb_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       iack_ni,
  input logic       irq_no,
  input logic [7:0] vec_o,
  input logic [7:0] ctrl,
  input logic       above,
  input logic       ack_d,
  input logic [1:0] cir_ch,
  input logic [2:0] cir_type
);
  p_irq_needs_bid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> $past(above));

  p_irq_quiet_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iack_ni |=> irq_no);

  p_irq_quiet_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_ni && !ack_d) |=> irq_no);

  p_record_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iack_ni && !ack_d) |=> ($stable(cir_ch) && $stable(cir_type)));

  p_vec_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl[1:0] == 2'b11) |-> (vec_o == 8'hFF));

  p_vec_ch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl[1:0] == 2'b01) |-> (vec_o[1:0] == cir_ch));
endmodule

bind prio_irq_arb prio_irq_arb_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .iack_ni(iack_ni), .irq_no(irq_no),
  .vec_o(vec_o), .ctrl(ctrl), .above(above), .ack_d(ack_d),
  .cir_ch(cir_ch), .cir_type(cir_type)
);

// File: tb/prio_irq_arb_test.sv
module prio_irq_arb_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] brk_req_i = '0, chg_req_i = '0;
  logic [1:0] ct_req_i = '0;
  logic       wr_en_i = 1'b0;
  logic [7:0] addr_i = '0, wdata_i = '0;
  logic [7:0] rdata_o, vec_o;
  logic       iack_ni = 1'b1;
  logic       irq_no;

  int errors = 0, checks = 0;

  logic [2:0] bp [4];
  logic [2:0] cp [4];
  logic [1:0] tp [4];
  logic [3:0] breq, creq;
  logic [1:0] treq;
  logic [5:0] thr;
  logic [7:0] base;
  logic [2:0] e_prio, e_ty;
  logic [1:0] e_ch;

  always #4 clk_i = ~clk_i;

  prio_irq_arb uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .brk_req_i(brk_req_i), .chg_req_i(chg_req_i),
    .ct_req_i(ct_req_i), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .iack_ni(iack_ni), .irq_no(irq_no), .vec_o(vec_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk_i);
    addr_i = a;
    #1 chk(req, rdata_o, exp);
  endtask

  // expected winner from R4/R5
  task automatic model();
    e_prio = 0; e_ch = 0; e_ty = 3'b000;
    for (int c = 0; c < 4; c++) begin
      if (breq[c] && bp[c] > e_prio) begin e_prio = bp[c]; e_ch = 2'(c); e_ty = 3'b001; end
      if (creq[c] && cp[c] > e_prio) begin e_prio = cp[c]; e_ch = 2'(c); e_ty = 3'b010; end
      if (c % 2 == 1 && treq[c/2] && {1'b0, tp[c]} > e_prio) begin
        e_prio = {1'b0, tp[c]}; e_ch = 2'(c); e_ty = 3'b100;
      end
    end
  endtask

  task automatic run_case(input string tag);
    logic exp_n;
    brk_req_i = breq; chg_req_i = creq; ct_req_i = treq;
    for (int c = 0; c < 4; c++) wr(8'h20 + 8'(c), {bp[c], cp[c], tp[c]});
    wr(8'h29, base);
    wr(8'h2C, {thr, 2'b00});
    model();
    exp_n = !({3'b000, e_prio} > thr);
    @(negedge clk_i);
    chk({"R3 R4 R5 irq ", tag}, {7'b0, irq_no}, {7'b0, exp_n});
    iack_ni = 1'b0;
    @(negedge clk_i);
    chk({"R9 irq in ack ", tag}, {7'b0, irq_no}, 8'h01);
    chk({"R6 R7 mode00 ", tag}, vec_o, base);
    brk_req_i = '0; chg_req_i = '0; ct_req_i = '0; // R6 freeze
    wr(8'h2C, {thr, 2'b01});
    chk({"R6 R7 mode01 ", tag}, vec_o, {base[7:2], e_ch});
    wr(8'h2C, {thr, 2'b10});
    chk({"R6 R7 mode10 ", tag}, vec_o, {base[7:5], e_ty, e_ch});
    wr(8'h2C, {thr, 2'b11});
    chk({"R8 mode11 ", tag}, vec_o, 8'hFF);
    brk_req_i = breq; chg_req_i = creq; ct_req_i = treq;
    iack_ni = 1'b1;
    @(negedge clk_i);
    chk({"R9 release gap ", tag}, {7'b0, irq_no}, 8'h01);
    @(negedge clk_i);
    chk({"R9 re-eval ", tag}, {7'b0, irq_no}, {7'b0, exp_n});
    wr(8'h2C, {thr, 2'b00});
  endtask

  task automatic clear_cfg();
    for (int c = 0; c < 4; c++) begin bp[c] = 0; cp[c] = 0; tp[c] = 0; end
    breq = 0; creq = 0; treq = 0; thr = 0; base = 8'hA5;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(7));
    #3 rst_ni = 1'b0;
    #10 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 irq reset", {7'b0, irq_no}, 8'h01);
    for (int c = 0; c < 4; c++) rd_chk("R1 bid reset", 8'h20 + 8'(c), 8'h00);
    rd_chk("R1 ctrl reset", 8'h2C, 8'h00);

    wr(8'h22, 8'h9E); rd_chk("R2 bid rw", 8'h22, 8'h9E);
    wr(8'h2C, 8'h5B); rd_chk("R2 ctrl rw", 8'h2C, 8'h5B);
    wr(8'h29, 8'h3C); rd_chk("R10 base write-only", 8'h29, 8'h00);
    wr(8'h2C, 8'h00); wr(8'h22, 8'h00);

    clear_cfg(); bp[2] = 5; bp[3] = 5; breq = 4'b1100; run_case("tie across ch");
    clear_cfg(); bp[1] = 4; cp[1] = 4; breq = 4'b0010; creq = 4'b0010; run_case("break before change");
    clear_cfg(); cp[0] = 3; bp[1] = 3; creq = 4'b0001; breq = 4'b0010; run_case("change ch0 vs break ch1");
    clear_cfg(); cp[1] = 3; tp[1] = 3; creq = 4'b0010; treq = 2'b01; run_case("change before timer");
    clear_cfg(); tp[1] = 3; treq = 2'b01; run_case("R5 timer0 code");
    clear_cfg(); tp[3] = 2; tp[1] = 1; treq = 2'b11; run_case("R5 timer1 code");
    clear_cfg(); bp[0] = 7; breq = 4'b0001; thr = 6'd7; run_case("R3 equal to threshold");
    clear_cfg(); bp[0] = 7; breq = 4'b0001; thr = 6'd6; run_case("R3 just above threshold");
    clear_cfg(); breq = 4'b1111; creq = 4'b1111; treq = 2'b11; run_case("R3 zero priorities");

    for (int i = 0; i < 120; i++) begin
      for (int c = 0; c < 4; c++) begin
        bp[c] = 3'($urandom); cp[c] = 3'($urandom); tp[c] = 2'($urandom);
      end
      breq = 4'($urandom); creq = 4'($urandom); treq = 2'($urandom);
      thr = 6'($urandom % 9); base = 8'($urandom);
      run_case("sweep");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule